// File: doc/BRIEF.md
# Video Input Capture Front End

This block sits at the pin side of a video input port. All of its logic runs on the video sample clock. On each rising edge it picks a 10-bit word and a qualifier. These come from the external camera pins or, in loopback, from the chip's own video output pins. It captures the word only while the qualifier is high and capture is enabled.

Each captured word leaves the block as a one-cycle pulse on a 10-bit output. The capture mode sets what that output holds:

- **8-bit YUV:** the low byte only.
- **10-bit raw:** the whole word.
- **Message passing:** the low byte, with bit 8 shown as a message-start flag and bit 9 as a message-end flag.

A small synchronous register bus, on the same clock, holds three registers: control, status and a clock-divider setting. A software reset command clears all three and then blocks every register write for a fixed number of clocks. A stay-awake bit lets capture continue while a chip-wide power-down request is asserted.

The design has two state machines:

- **Register machine:** states `RS_RUN` and `RS_LOCK`. Transition *srst_hit* goes RUN to LOCK. Transition *lock_done* goes LOCK to RUN when the counter reaches its last cycle.
- **Capture machine:** states `CS_IDLE`, `CS_ACTIVE` and `CS_SLEEP`.
  - *enable* goes IDLE to ACTIVE, or IDLE to SLEEP if a halt is pending.
  - *disable* goes ACTIVE or SLEEP to IDLE.
  - *halt* goes ACTIVE to SLEEP.
  - *wake* goes SLEEP to ACTIVE.

Top module: `vcap_frontend`

## Requirements
- R1: A word is captured only at a rising edge where the selected qualifier is high and control bit 0 (enable) is 1. The capture appears on `cap_valid` for exactly one cycle after that edge. With the qualifier low or enable 0, no capture occurs.
- R2: With control bits 2:1 = 0 (8-bit YUV), the output is the input bits 7:0 with bits 9:8 forced to zero. Code 3 behaves like code 0. `cap_start` and `cap_end` stay 0.
- R3: With control bits 2:1 = 1 (10-bit raw), all 10 input bits appear unchanged on `cap_data`.
- R4: With control bits 2:1 = 2 (message passing), `cap_data` carries input bits 7:0 with bits 9:8 at zero. Input bit 8 drives `cap_start` and input bit 9 drives `cap_end`. Both flags pulse together with `cap_valid`.
- R5: Control bit 3 (loopback) selects the loopback data and qualifier inputs. When it is clear, the pin inputs are used. The unselected source has no effect.
- R6: After hardware reset, control (address 0), status (address 1) and clock divider (address 2, 8 bits) read zero, and `cap_valid` is 0.
- R7: A control write with bit 19 set, for example 0x00080000, is a software reset. It clears control (including loopback), status and the clock divider, and discards the other bits of that write. Bit 19 always reads back 0.
- R8: After a software reset, status bit 0 (busy) reads 1 for 5 clocks. Every register write sampled during those 5 clocks is ignored. The first write after them takes effect.
- R9: While `pwr_down` is high and control bit 4 (stay-awake) is 0, nothing is captured. One clock after capture halts, status bit 1 (asleep) reads 1.
- R10: With control bit 4 set, capture continues normally while `pwr_down` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | video sample clock |
| rst_n | input | 1 | hardware reset, active low |
| pin_data | input | 10 | external video data pins |
| pin_valid | input | 1 | external data qualifier |
| lb_data | input | 10 | loopback data from video output pins |
| lb_valid | input | 1 | loopback data qualifier |
| pwr_down | input | 1 | chip-wide power-down request |
| reg_wr_en | input | 1 | register write strobe |
| reg_addr | input | 2 | register address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr` (combinational) |
| cap_valid | output | 1 | one-cycle capture pulse |
| cap_data | output | 10 | captured word |
| cap_start | output | 1 | message start flag |
| cap_end | output | 1 | message end flag |

## Verification
The bench builds the block with its defaults: a 10-bit data path, a 5-clock lockout and an 8-bit divider register. A 5-clock lockout is short enough to probe each blocked write and the first accepted one one by one. With 10 bits, the raw-mode upper bits and both message flags can be driven directly from the pins. The directed scenarios move between modes, sources and power states on live traffic, so the enable, halt and wake transitions of the capture machine are all exercised.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        MODE_YUV8  = 2'd0,
        MODE_RAW10 = 2'd1,
        MODE_MSG   = 2'd2,
        MODE_RSVD  = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_ACTIVE = 2'd1,
        CS_SLEEP  = 2'd2
    } cap_state_e;

    typedef enum logic {
        RS_RUN  = 1'b0,
        RS_LOCK = 1'b1
    } reg_state_e;

    typedef struct packed {
        logic      awake;
        logic      loop;
        cap_mode_e mode;
        logic      en;
    } cap_cfg_t;

    localparam int ADDR_CTL  = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_CLK  = 2;

    localparam int CTL_EN    = 0;
    localparam int CTL_MODE  = 1;
    localparam int CTL_LOOP  = 3;
    localparam int CTL_AWAKE = 4;
    localparam int CTL_SRST  = 19;

    localparam int LO_W = 8;

endpackage

// File: rtl/vcap_srcmux.sv
module vcap_srcmux #(
    parameter int DATA_W = 10
) (
    input  logic              sel_loop,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              pin_valid,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              lb_valid,
    output logic [DATA_W-1:0] mux_data,
    output logic              mux_valid
);

    always_comb begin
        if (sel_loop) begin
            mux_data  = lb_data;
            mux_valid = lb_valid;
        end else begin
            mux_data  = pin_data;
            mux_valid = pin_valid;
        end
    end

endmodule

// File: rtl/vcap_regs.sv
module vcap_regs
    import vcap_pkg::*;
#(
    parameter int LOCKOUT_CYC = 5,
    parameter int CLKDIV_W    = 8,
    parameter int REG_AW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              asleep,
    output logic [31:0]       rdata,
    output cap_cfg_t          cfg,
    output logic              busy
);

    localparam int CNT_W = $clog2(LOCKOUT_CYC + 1);

    reg_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    cap_cfg_t            cfg_q;
    logic [CLKDIV_W-1:0] clkdiv_q;
    logic                wr_ok, ctl_wr, clk_wr, srst_hit;
    logic                unused_wdata;

    assign wr_ok    = wr_en && (state_q == RS_RUN);
    assign ctl_wr   = wr_ok && (addr == REG_AW'(ADDR_CTL));
    assign clk_wr   = wr_ok && (addr == REG_AW'(ADDR_CLK));
    assign srst_hit = ctl_wr && wdata[CTL_SRST];
    assign unused_wdata = ^{wdata[31:CTL_SRST+1], wdata[CTL_SRST-1:CTL_AWAKE+1]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_RUN:  if (srst_hit) state_d = RS_LOCK;
            RS_LOCK: if (cnt_q == CNT_W'(1)) state_d = RS_RUN;
            default: state_d = RS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cfg_q    <= '0;
            clkdiv_q <= '0;
        end else begin
            if (srst_hit) begin
                cnt_q    <= CNT_W'(LOCKOUT_CYC);
                cfg_q    <= '0;
                clkdiv_q <= '0;
            end else begin
                if (state_q == RS_LOCK) cnt_q <= cnt_q - CNT_W'(1);
                if (ctl_wr) begin
                    cfg_q.en    <= wdata[CTL_EN];
                    cfg_q.mode  <= cap_mode_e'(wdata[CTL_MODE+1:CTL_MODE]);
                    cfg_q.loop  <= wdata[CTL_LOOP];
                    cfg_q.awake <= wdata[CTL_AWAKE];
                end
                if (clk_wr) clkdiv_q <= wdata[CLKDIV_W-1:0];
            end
        end
    end

    assign cfg  = cfg_q;
    assign busy = (state_q == RS_LOCK);

    always_comb begin
        unique case (addr)
            REG_AW'(ADDR_CTL):  rdata = 32'({cfg_q.awake, cfg_q.loop, cfg_q.mode, cfg_q.en});
            REG_AW'(ADDR_STAT): rdata = 32'({asleep, busy});
            REG_AW'(ADDR_CLK):  rdata = 32'(clkdiv_q);
            default:            rdata = '0;
        endcase
    end

endmodule

// File: rtl/vcap_sampler.sv
module vcap_sampler
    import vcap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cap_cfg_t          cfg,
    input  logic              pwr_down,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_start,
    output logic              cap_end,
    output logic              asleep
);

    cap_state_e        state_q, state_d;
    logic              halt, fire;
    logic [DATA_W-1:0] data_sel;
    logic              start_sel, end_sel;

    assign halt = pwr_down && !cfg.awake;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (cfg.en) state_d = halt ? CS_SLEEP : CS_ACTIVE;
            CS_ACTIVE: if (!cfg.en) state_d = CS_IDLE;
                       else if (halt) state_d = CS_SLEEP;
            CS_SLEEP:  if (!cfg.en) state_d = CS_IDLE;
                       else if (!halt) state_d = CS_ACTIVE;
            default:   state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    assign fire   = (state_d == CS_ACTIVE) && in_valid;
    assign asleep = (state_q == CS_SLEEP);

    always_comb begin
        data_sel  = DATA_W'(in_data[LO_W-1:0]);
        start_sel = 1'b0;
        end_sel   = 1'b0;
        unique case (cfg.mode)
            MODE_RAW10: data_sel = in_data;
            MODE_MSG: begin
                start_sel = in_data[LO_W];
                end_sel   = in_data[LO_W+1];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
            cap_start <= 1'b0;
            cap_end   <= 1'b0;
        end else begin
            cap_valid <= fire;
            cap_start <= fire && start_sel;
            cap_end   <= fire && end_sel;
            if (fire) cap_data <= data_sel;
        end
    end

endmodule

// File: rtl/vcap_frontend.sv
module vcap_frontend
    import vcap_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LOCKOUT_CYC = 5,
    parameter int CLKDIV_W    = 8,
    parameter int REG_AW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              pin_valid,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              lb_valid,
    input  logic              pwr_down,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_start,
    output logic              cap_end
);

    cap_cfg_t          cfg;
    logic              busy, asleep, mux_valid;
    logic [DATA_W-1:0] mux_data;

    vcap_regs #(
        .LOCKOUT_CYC(LOCKOUT_CYC),
        .CLKDIV_W   (CLKDIV_W),
        .REG_AW     (REG_AW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .asleep (asleep),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .busy   (busy)
    );

    vcap_srcmux #(.DATA_W(DATA_W)) u_mux (
        .sel_loop  (cfg.loop),
        .pin_data  (pin_data),
        .pin_valid (pin_valid),
        .lb_data   (lb_data),
        .lb_valid  (lb_valid),
        .mux_data  (mux_data),
        .mux_valid (mux_valid)
    );

    vcap_sampler #(.DATA_W(DATA_W)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .pwr_down  (pwr_down),
        .in_data   (mux_data),
        .in_valid  (mux_valid),
        .cap_valid (cap_valid),
        .cap_data  (cap_data),
        .cap_start (cap_start),
        .cap_end   (cap_end),
        .asleep    (asleep)
    );

endmodule

// File: rtl/vcap_frontend_chk.sv
module vcap_frontend_chk
    import vcap_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int REG_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input cap_cfg_t          cfg,
    input logic              busy,
    input logic              mux_valid,
    input logic              pwr_down,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              cap_valid,
    input logic [DATA_W-1:0] cap_data,
    input logic              cap_start,
    input logic              cap_end
);

    AST_CAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(mux_valid));  // R1

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && $past(cfg.mode) != MODE_RAW10) |-> (cap_data[DATA_W-1:LO_W] == '0));  // R2

    AST_FLAGS_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_start || cap_end) |-> (cap_valid && $past(cfg.mode) == MODE_MSG));  // R4

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == REG_AW'(ADDR_CTL) && reg_wdata[CTL_SRST] && !busy)
        |=> (busy && !cfg.en && !cfg.loop && !cfg.awake));  // R7

    AST_LOCK_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !cap_valid);  // R8

    AST_SLEEP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !cfg.awake) |=> !cap_valid);  // R9

endmodule

bind vcap_frontend vcap_frontend_chk #(
    .DATA_W(DATA_W),
    .REG_AW(REG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .busy      (busy),
    .mux_valid (mux_valid),
    .pwr_down  (pwr_down),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cap_valid (cap_valid),
    .cap_data  (cap_data),
    .cap_start (cap_start),
    .cap_end   (cap_end)
);

// File: tb/sim_vcap_frontend.sv
module sim_vcap_frontend;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pin_data = '0, lb_data = '0;
    logic        pin_valid = 1'b0, lb_valid = 1'b0, pwr_down = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_valid, cap_start, cap_end;
    logic [9:0]  cap_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcap_frontend u0 (
        .clk(clk), .rst_n(rst_n),
        .pin_data(pin_data), .pin_valid(pin_valid),
        .lb_data(lb_data), .lb_valid(lb_valid),
        .pwr_down(pwr_down),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .cap_start(cap_start), .cap_end(cap_end)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input logic [9:0] pd, input logic pv, input logic [9:0] ld, input logic lv);
        pin_data = pd; pin_valid = pv; lb_data = ld; lb_valid = lv;
        @(negedge clk);
        pin_valid = 1'b0; lb_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(2'd0, v); chk_eq("R6 ctl", v, 32'h0);
        rd_reg(2'd1, v); chk_eq("R6 status", v, 32'h0);
        rd_reg(2'd2, v); chk_eq("R6 clkdiv", v, 32'h0);
        chk_eq("R6 cap_valid", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_yuv();
        wr_reg(2'd0, 32'h1);
        push(10'h3A5, 1'b1, 10'h0, 1'b0);
        chk_eq("R1 pulse", 32'(cap_valid), 32'h1);
        chk_eq("R2 data", 32'(cap_data), 32'h0A5);
        chk_eq("R2 flags", 32'({cap_start, cap_end}), 32'h0);
        @(negedge clk);
        chk_eq("R1 one cycle", 32'(cap_valid), 32'h0);
        push(10'h155, 1'b0, 10'h0, 1'b0);
        chk_eq("R1 valid low", 32'(cap_valid), 32'h0);
        wr_reg(2'd0, 32'h7);
        push(10'h2FF, 1'b1, 10'h0, 1'b0);
        chk_eq("R2 code3 data", 32'(cap_data), 32'h0FF);
        wr_reg(2'd0, 32'h0);
        push(10'h111, 1'b1, 10'h0, 1'b0);
        chk_eq("R1 disabled", 32'(cap_valid), 32'h0);
    endtask

    task automatic t_raw();
        wr_reg(2'd0, 32'h3);
        push(10'h2C7, 1'b1, 10'h0, 1'b0);
        chk_eq("R3 valid", 32'(cap_valid), 32'h1);
        chk_eq("R3 data", 32'(cap_data), 32'h2C7);
    endtask

    task automatic t_msg();
        wr_reg(2'd0, 32'h5);
        push(10'h1F0, 1'b1, 10'h0, 1'b0);
        chk_eq("R4 start data", 32'(cap_data), 32'h0F0);
        chk_eq("R4 start flags", 32'({cap_start, cap_end}), 32'h2);
        push(10'h20F, 1'b1, 10'h0, 1'b0);
        chk_eq("R4 end data", 32'(cap_data), 32'h00F);
        chk_eq("R4 end flags", 32'({cap_start, cap_end}), 32'h1);
        @(negedge clk);
        chk_eq("R4 flags drop", 32'({cap_valid, cap_start, cap_end}), 32'h0);
    endtask

    task automatic t_loop();
        wr_reg(2'd0, 32'h9);
        push(10'h011, 1'b1, 10'h0BB, 1'b1);
        chk_eq("R5 loop data", 32'(cap_data), 32'h0BB);
        push(10'h022, 1'b1, 10'h0CC, 1'b0);
        chk_eq("R5 pin ignored", 32'(cap_valid), 32'h0);
        wr_reg(2'd0, 32'h1);
        push(10'h033, 1'b1, 10'h0DD, 1'b1);
        chk_eq("R5 pin data", 32'(cap_data), 32'h033);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr_reg(2'd2, 32'h5A);
        rd_reg(2'd2, v); chk_eq("R7 clkdiv set", v, 32'h5A);
        wr_reg(2'd0, 32'h19);
        wr_reg(2'd0, 32'h0008_0000);
        rd_reg(2'd0, v); chk_eq("R7 ctl cleared", v, 32'h0);
        rd_reg(2'd2, v); chk_eq("R7 clkdiv cleared", v, 32'h0);
        rd_reg(2'd1, v); chk_eq("R8 busy", v, 32'h1);
        for (int i = 0; i < 5; i++) begin
            wr_reg(2'd0, 32'h3);
            rd_reg(2'd0, v); chk_eq("R8 write blocked", v, 32'h0);
        end
        rd_reg(2'd1, v); chk_eq("R8 busy cleared", v, 32'h0);
        wr_reg(2'd0, 32'h3);
        rd_reg(2'd0, v); chk_eq("R8 write accepted", v, 32'h3);
        push(10'h044, 1'b0, 10'h0EE, 1'b1);
        chk_eq("R7 loopback cleared", 32'(cap_valid), 32'h0);
        wr_reg(2'd0, 32'h9);
        push(10'h044, 1'b0, 10'h0EE, 1'b1);
        chk_eq("R7 loopback restored", 32'(cap_data), 32'h0EE);
    endtask

    task automatic t_power();
        logic [31:0] v;
        wr_reg(2'd0, 32'h1);
        pwr_down = 1'b1;
        push(10'h055, 1'b1, 10'h0, 1'b0);
        chk_eq("R9 no capture", 32'(cap_valid), 32'h0);
        rd_reg(2'd1, v); chk_eq("R9 asleep", v, 32'h2);
        wr_reg(2'd0, 32'h11);
        push(10'h066, 1'b1, 10'h0, 1'b0);
        chk_eq("R10 capture awake", 32'(cap_valid), 32'h1);
        chk_eq("R10 data", 32'(cap_data), 32'h066);
        pwr_down = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_yuv();
        t_raw();
        t_msg();
        t_loop();
        t_srst();
        t_power();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule